// File: doc/BRIEF.md
# Scalable Identifier Acceptance Filter

This block decides whether a received frame is kept, judging only by its identifier. A set of filter banks is compared in parallel against the frame's 11-bit standard identifier, its 18-bit extended identifier, the identifier-extension flag (IDE) and the remote-request flag (RTR). A frame that hits any enabled filter produces a one-cycle accept pulse together with the index of the filter that won. A frame that hits nothing is dropped without a pulse.

Every bank holds two 32-bit words and three control bits: an enable, a scale bit and a mode bit. At wide scale a bank forms a single filter covering the whole identifier. At narrow scale it forms two filters covering the standard identifier, the two flags and the top three extended-identifier bits. In mask mode one part of the bank holds an identifier and the other holds a care mask. In list mode every part holds an exact identifier, so each bank yields two wide entries or four narrow ones. The number of banks is a parameter, and the full-size configuration is 28.

Top module: `id_accept_filter`

## Requirements
- R1: While rst_ni is low, and until the first valid identifier, accept_o is 0 and match_idx_o is 0.
- R2: The wide compare word is {std[10:0], ext[17:0], ide, rtr, 1'b0}, MSB first. With scale=1 and mode=0, a bank hits on entry 0 when ((word ^ r0) & r1) == 0. A 1 in r1 marks a bit that must match.
- R3: With scale=1 and mode=1, a bank hits on entry 0 when the wide word equals r0, and on entry 1 when it equals r1.
- R4: The narrow compare word is {std[10:0], rtr, ide, ext[17:15]}, MSB first. With scale=0 and mode=0, entry 0 uses r0[15:0] as identifier and r0[31:16] as mask, and entry 1 uses r1[15:0] and r1[31:16] in the same way.
- R5: With scale=0 and mode=1, entries 0 to 3 hit on an exact match of the narrow word with r0[15:0], r0[31:16], r1[15:0] and r1[31:16] respectively.
- R6: match_idx_o = bank*4 + entry. When several entries hit, the lowest bank wins, and within that bank the lowest entry wins.
- R7: A bank whose enable bit is 0 never hits, whatever its words hold.
- R8: A valid identifier that hits nothing gives no accept pulse, and match_idx_o keeps its previous value.
- R9: accept_o is high for exactly the cycle after the clock edge that samples id_valid_i high with a hit. match_idx_o changes only together with such a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Identifier fields valid this cycle |
| std_id_i | input | 11 | Standard identifier |
| ext_id_i | input | 18 | Extended identifier |
| ide_i | input | 1 | Identifier-extension flag |
| rtr_i | input | 1 | Remote-request flag |
| bank_en_i | input | NUM_BANKS | Per-bank enable |
| bank_scale_i | input | NUM_BANKS | 1 = one wide filter, 0 = narrow filters |
| bank_mode_i | input | NUM_BANKS | 1 = identifier list, 0 = mask |
| bank_r0_i | input | 32*NUM_BANKS | First word of each bank, bank b at [32b +: 32] |
| bank_r1_i | input | 32*NUM_BANKS | Second word of each bank, bank b at [32b +: 32] |
| accept_o | output | 1 | One-cycle accept pulse |
| match_idx_o | output | log2(4*NUM_BANKS) | Index of the winning filter |

## Verification
Both results come from one register stage. For a valid identifier driven before a rising edge, accept_o and match_idx_o hold the verdict from that edge until the next one. The bench drives each identifier on a falling edge and reads the outputs on the following falling edge, half a period after the capturing edge. It then compares them with a reference model that applies the packing, mode and priority rules directly to the bank words it has driven. For rejected frames the expected index is the last accepted index that the bench recorded, which checks that the index holds. Idle cycles confirm that no pulse appears without a valid identifier.

// File: rtl/filt_pkg.sv
package filt_pkg;
  localparam int STD_W      = 11;
  localparam int EXT_W      = 18;
  localparam int WIDE_W     = 32;
  localparam int NARROW_W   = 16;
  localparam int ENT_PER_BK = 4;
  localparam int EXT_TOP_W  = 3;

  typedef struct packed {
    logic [STD_W-1:0] std_id;
    logic [EXT_W-1:0] ext_id;
    logic             ide;
    logic             rtr;
  } frame_id_t;
endpackage

// File: rtl/filt_word_pack.sv
module filt_word_pack
  import filt_pkg::*;
(
  input  frame_id_t             frame_i,
  output logic [WIDE_W-1:0]     wide_o,
  output logic [NARROW_W-1:0]   narrow_o
);
  // wide: std, ext, ide, rtr, pad; narrow: std, rtr, ide, ext top bits
  assign wide_o   = {frame_i.std_id, frame_i.ext_id, frame_i.ide, frame_i.rtr, 1'b0};
  assign narrow_o = {frame_i.std_id, frame_i.rtr, frame_i.ide,
                     frame_i.ext_id[EXT_W-1 -: EXT_TOP_W]};
endmodule

// File: rtl/filt_bank.sv
module filt_bank
  import filt_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [WIDE_W-1:0]     wide_i,
  input  logic [NARROW_W-1:0]   narrow_i,
  input  logic [WIDE_W-1:0]     r0_i,
  input  logic [WIDE_W-1:0]     r1_i,
  input  logic                  en_i,
  input  logic                  scale_i,
  input  logic                  mode_i,
  output logic [ENT_PER_BK-1:0] hit_o
);
  localparam int NUM_HALF = 4;

  logic [NARROW_W-1:0] half_w [NUM_HALF];
  logic [NUM_HALF-1:0] half_eq;
  logic                wide_mask_hit, wide_eq0, wide_eq1;
  logic                nar_mask_hit0, nar_mask_hit1;

  // halves ordered r0 low, r0 high, r1 low, r1 high
  genvar k;
  generate
    for (k = 0; k < NUM_HALF; k++) begin : g_half
      if (k < 2) begin : g_r0
        assign half_w[k] = r0_i[k*NARROW_W +: NARROW_W];
      end else begin : g_r1
        assign half_w[k] = r1_i[(k-2)*NARROW_W +: NARROW_W];
      end
      assign half_eq[k] = (narrow_i == half_w[k]);
    end
  endgenerate

  assign wide_mask_hit = (((wide_i ^ r0_i) & r1_i) == '0);
  assign wide_eq0      = (wide_i == r0_i);
  assign wide_eq1      = (wide_i == r1_i);
  assign nar_mask_hit0 = (((narrow_i ^ half_w[0]) & half_w[1]) == '0);
  assign nar_mask_hit1 = (((narrow_i ^ half_w[2]) & half_w[3]) == '0);

  always_comb begin
    hit_o = '0;
    if (en_i) begin
      unique case ({scale_i, mode_i})
        2'b10:   hit_o = {3'b000, wide_mask_hit};
        2'b11:   hit_o = {2'b00, wide_eq1, wide_eq0};
        2'b00:   hit_o = {2'b00, nar_mask_hit1, nar_mask_hit0};
        default: hit_o = half_eq;
      endcase
    end
  end

  p_wide_mask_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scale_i && !mode_i) |-> (hit_o[3:1] == 3'b000));
  p_wide_list_two_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scale_i && mode_i) |-> (hit_o[3:2] == 2'b00));
  p_narrow_mask_two_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scale_i && !mode_i) |-> (hit_o[3:2] == 2'b00));
endmodule

// File: rtl/filt_prio.sv
module filt_prio #(
  parameter  int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     hits_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (hits_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |hits_i;

  p_lowest_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (hits_i[idx_o] && ((hits_i & ((N'(1) << idx_o) - N'(1))) == '0)));
  p_idle_zero_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_o |-> (idx_o == '0));
endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter
  import filt_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int NUM_ENT   = NUM_BANKS * ENT_PER_BK,
  localparam int IDX_W     = $clog2(NUM_ENT)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        id_valid_i,
  input  logic [STD_W-1:0]            std_id_i,
  input  logic [EXT_W-1:0]            ext_id_i,
  input  logic                        ide_i,
  input  logic                        rtr_i,
  input  logic [NUM_BANKS-1:0]        bank_en_i,
  input  logic [NUM_BANKS-1:0]        bank_scale_i,
  input  logic [NUM_BANKS-1:0]        bank_mode_i,
  input  logic [NUM_BANKS*WIDE_W-1:0] bank_r0_i,
  input  logic [NUM_BANKS*WIDE_W-1:0] bank_r1_i,
  output logic                        accept_o,
  output logic [IDX_W-1:0]            match_idx_o
);
  frame_id_t           frame;
  logic [WIDE_W-1:0]   wide_w;
  logic [NARROW_W-1:0] narrow_w;
  logic [NUM_ENT-1:0]  hits;
  logic                any_hit;
  logic [IDX_W-1:0]    win_idx;
  logic                accept_q;
  logic [IDX_W-1:0]    idx_q;

  assign frame = '{std_id: std_id_i, ext_id: ext_id_i, ide: ide_i, rtr: rtr_i};

  filt_word_pack i_pack (
    .frame_i  (frame),
    .wide_o   (wide_w),
    .narrow_o (narrow_w)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      filt_bank i_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wide_i   (wide_w),
        .narrow_i (narrow_w),
        .r0_i     (bank_r0_i[b*WIDE_W +: WIDE_W]),
        .r1_i     (bank_r1_i[b*WIDE_W +: WIDE_W]),
        .en_i     (bank_en_i[b]),
        .scale_i  (bank_scale_i[b]),
        .mode_i   (bank_mode_i[b]),
        .hit_o    (hits[b*ENT_PER_BK +: ENT_PER_BK])
      );
      p_off_bank_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bank_en_i[b] |-> (hits[b*ENT_PER_BK +: ENT_PER_BK] == '0));
    end
  endgenerate

  filt_prio #(.N(NUM_ENT)) i_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hits_i (hits),
    .any_o  (any_hit),
    .idx_o  (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      accept_q <= id_valid_i && any_hit;
      if (id_valid_i && any_hit) idx_q <= win_idx;
    end
  end

  assign accept_o    = accept_q;
  assign match_idx_o = idx_q;

  p_pulse_needs_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(id_valid_i));
  p_idx_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_o |-> $stable(match_idx_o));
  p_miss_no_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && !any_hit) |=> !accept_o);
endmodule

// File: tb/test_id_accept_filter.sv
`timescale 1ns/1ps
module test_id_accept_filter;
  localparam int NB    = 4;
  localparam int IDX_W = $clog2(NB*4);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             id_valid_i = 1'b0;
  logic [10:0]      std_id_i = '0;
  logic [17:0]      ext_id_i = '0;
  logic             ide_i = 1'b0;
  logic             rtr_i = 1'b0;
  logic [NB-1:0]    bank_en_i = '0;
  logic [NB-1:0]    bank_scale_i = '0;
  logic [NB-1:0]    bank_mode_i = '0;
  logic [NB*32-1:0] bank_r0_i = '0;
  logic [NB*32-1:0] bank_r1_i = '0;
  logic             accept_o;
  logic [IDX_W-1:0] match_idx_o;

  int n_chk = 0;
  int n_bad = 0;
  int last_idx = 0;

  always #4 clk = ~clk;

  id_accept_filter #(.NUM_BANKS(NB)) i_id_accept_filter (
    .clk_i(clk), .rst_ni(rst_ni), .id_valid_i(id_valid_i),
    .std_id_i(std_id_i), .ext_id_i(ext_id_i), .ide_i(ide_i), .rtr_i(rtr_i),
    .bank_en_i(bank_en_i), .bank_scale_i(bank_scale_i), .bank_mode_i(bank_mode_i),
    .bank_r0_i(bank_r0_i), .bank_r1_i(bank_r1_i),
    .accept_o(accept_o), .match_idx_o(match_idx_o)
  );

  function automatic logic [31:0] wide(input logic [10:0] s, input logic [17:0] e,
                                       input logic i, input logic r);
    return {s, e, i, r, 1'b0};
  endfunction

  function automatic logic [15:0] narrow(input logic [10:0] s, input logic [17:0] e,
                                         input logic i, input logic r);
    return {s, r, i, e[17:15]};
  endfunction

  function automatic void model(input logic [10:0] s, input logic [17:0] e,
                                input logic i, input logic r,
                                output bit acc, output int idx);
    logic [31:0] w, a, m;
    logic [15:0] n;
    logic [15:0] h [4];
    logic [3:0]  hv;
    w = wide(s, e, i, r);
    n = narrow(s, e, i, r);
    acc = 1'b0;
    idx = 0;
    for (int b = 0; b < NB; b++) begin
      a = bank_r0_i[b*32 +: 32];
      m = bank_r1_i[b*32 +: 32];
      h[0] = a[15:0]; h[1] = a[31:16]; h[2] = m[15:0]; h[3] = m[31:16];
      hv = '0;
      if (bank_en_i[b]) begin
        if (bank_scale_i[b] && !bank_mode_i[b]) hv[0] = ((w & m) == (a & m));
        else if (bank_scale_i[b]) begin
          hv[0] = (w == a); hv[1] = (w == m);
        end else if (!bank_mode_i[b]) begin
          hv[0] = ((n & h[1]) == (h[0] & h[1]));
          hv[1] = ((n & h[3]) == (h[2] & h[3]));
        end else begin
          for (int k = 0; k < 4; k++) hv[k] = (n == h[k]);
        end
      end
      for (int k = 0; k < 4; k++) begin
        if (hv[k] && !acc) begin
          acc = 1'b1;
          idx = b*4 + k;
        end
      end
    end
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_bank(input int b, input logic [31:0] r0, input logic [31:0] r1,
                          input logic en, input logic sc, input logic md);
    bank_r0_i[b*32 +: 32] = r0;
    bank_r1_i[b*32 +: 32] = r1;
    bank_en_i[b] = en;
    bank_scale_i[b] = sc;
    bank_mode_i[b] = md;
  endtask

  // drive on falling edge, read one full period later
  task automatic send(input string req, input logic [10:0] s, input logic [17:0] e,
                      input logic i, input logic r);
    bit acc;
    int idx;
    model(s, e, i, r, acc, idx);
    std_id_i = s; ext_id_i = e; ide_i = i; rtr_i = r; id_valid_i = 1'b1;
    @(negedge clk);
    id_valid_i = 1'b0;
    check(req, int'(accept_o), int'(acc));
    if (acc) last_idx = idx;
    check(req, int'(match_idx_o), last_idx);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    check(req, int'(accept_o), 0);
    check(req, int'(match_idx_o), last_idx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9: watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [10:0] ss [8];
    logic [17:0] se [8];
    logic [7:0]  sf;
    logic [10:0] s;
    logic [17:0] e;
    int          p;
    void'($urandom(32'd5150));

    repeat (3) @(negedge clk);
    check("R1", int'(accept_o), 0);
    check("R1", int'(match_idx_o), 0);
    rst_ni = 1'b1;
    idle("R1");

    // R7: match-all bank disabled, later bank takes it
    set_bank(0, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    set_bank(1, wide(11'h123, 18'h2A5A5, 1'b1, 1'b0), 32'hFFFF_FFFE, 1'b1, 1'b1, 1'b0);
    send("R7", 11'h123, 18'h2A5A5, 1'b1, 1'b0);
    check("R7", int'(match_idx_o), 4);
    send("R8", 11'h124, 18'h2A5A5, 1'b1, 1'b0);
    check("R8", int'(match_idx_o), 4);
    idle("R9");

    // R2: wide mask, ext bits don't care
    set_bank(1, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    set_bank(0, wide(11'h7F0, 18'h0, 1'b0, 1'b1), {11'h7FF, 18'h0, 3'b110}, 1'b1, 1'b1, 1'b0);
    send("R2", 11'h7F0, 18'h3FFFF, 1'b0, 1'b1);
    check("R2", int'(match_idx_o), 0);
    send("R2", 11'h7F1, 18'h0, 1'b0, 1'b1);

    // R3: wide list, second word hits
    set_bank(0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    set_bank(2, wide(11'h001, 18'h11111, 1'b1, 1'b0), wide(11'h002, 18'h22222, 1'b1, 1'b1),
             1'b1, 1'b1, 1'b1);
    send("R3", 11'h002, 18'h22222, 1'b1, 1'b1);
    check("R3", int'(match_idx_o), 9);
    send("R3", 11'h002, 18'h22223, 1'b1, 1'b1);

    // R4: narrow mask, second filter; low ext bits ignored
    set_bank(1, {16'hFFFF, narrow(11'h555, 18'h0, 1'b0, 1'b0)},
                {16'hFFFF, narrow(11'h0AA, 18'h38000, 1'b0, 1'b0)}, 1'b1, 1'b0, 1'b0);
    send("R4", 11'h0AA, 18'h38123, 1'b0, 1'b0);
    check("R4", int'(match_idx_o), 5);

    // R5: narrow list, entry 3; R6: lower bank wins over bank 3
    set_bank(3, {narrow(11'h3, 18'h0, 1'b0, 1'b0), narrow(11'h2, 18'h0, 1'b0, 1'b0)},
                {narrow(11'h7, 18'h0, 1'b1, 1'b0), narrow(11'h6, 18'h0, 1'b0, 1'b1)},
                1'b1, 1'b0, 1'b1);
    send("R5", 11'h7, 18'h00FFF, 1'b1, 1'b0);
    check("R5", int'(match_idx_o), 15);
    set_bank(2, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0);
    send("R6", 11'h7, 18'h00FFF, 1'b1, 1'b0);
    check("R6", int'(match_idx_o), 8);
    idle("R9");

    // random phase, R6 across all modes
    for (int t = 0; t < 600; t++) begin
      if (t % 30 == 0) begin
        for (int k = 0; k < 8; k++) begin
          ss[k] = 11'($urandom); se[k] = 18'($urandom);
        end
        sf = 8'($urandom);
        for (int b = 0; b < NB; b++) begin
          logic [31:0] r0, r1;
          int a0, a1;
          a0 = $urandom_range(0, 7); a1 = $urandom_range(0, 7);
          case ($urandom_range(0, 3))
            0: begin
              r0 = wide(ss[a0], se[a0], sf[a0], sf[a1]);
              r1 = $urandom & $urandom & 32'hFFFF_FFFE;
              set_bank(b, r0, r1, ($urandom_range(0, 4) != 0), 1'b1, 1'b0);
            end
            1: set_bank(b, wide(ss[a0], se[a0], sf[a0], sf[a1]), wide(ss[a1], se[a1], sf[a1], sf[a0]),
                        ($urandom_range(0, 4) != 0), 1'b1, 1'b1);
            2: set_bank(b, {16'($urandom & $urandom), narrow(ss[a0], se[a0], sf[a0], sf[a1])},
                           {16'($urandom & $urandom), narrow(ss[a1], se[a1], sf[a1], sf[a0])},
                        ($urandom_range(0, 4) != 0), 1'b0, 1'b0);
            default: set_bank(b, {narrow(ss[a1], se[a1], sf[a0], sf[a0]), narrow(ss[a0], se[a0], sf[a0], sf[a1])},
                                 {narrow(ss[a0], se[a0], sf[a1], sf[a1]), narrow(ss[a1], se[a1], sf[a1], sf[a0])},
                              ($urandom_range(0, 4) != 0), 1'b0, 1'b1);
          endcase
        end
      end
      if ($urandom_range(0, 9) == 0) idle("R9");
      else begin
        p = $urandom_range(0, 7);
        if ($urandom_range(0, 1) == 1) begin
          s = ss[p]; e = se[p];
          if ($urandom_range(0, 2) == 0) e[$urandom_range(0, 17)] ^= 1'b1;
          send("R6", s, e, sf[p], sf[$urandom_range(0, 7)]);
        end else begin
          send("R6", 11'($urandom), 18'($urandom), 1'($urandom), 1'($urandom));
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule